// File: doc/BRIEF.md
# Configuration Readback Command Sequencer

This block reads back a run of configuration frames through a 32-bit internal configuration port. A start pulse supplies a starting frame address and a frame count. The block then writes a fixed command stream into the port. That stream synchronises the port, clears its CRC, selects readback mode, loads the frame address and requests the needed number of words from the frame-data output register. After that the block turns the port round to read mode and pulls the words out one per cycle.

The port always returns one pipeline dummy frame of 81 words before the real data. The block drops that frame in silence. Every later word goes out on a valid/ready stream, and the final word of the final frame is marked. The port reads only while the output holding register can take a word, so a slow consumer stalls the port with no loss of data. When the last word has been taken, a one-cycle done pulse follows. A request whose word count will not fit the 11-bit count field of the read header is refused with a one-cycle error pulse, and the port sees no activity.

The state machine has five states. IDLE waits for start: a valid request goes to SEND, and a refused request stays in IDLE and raises the error. SEND emits one command word per cycle and goes to GAP after the 18th word. GAP is a single turnaround cycle and always goes to READ. READ goes to FLUSH when the final word has been read from the port. FLUSH goes back to IDLE when the consumer accepts that final word.

Top module: `rb_readback_seq`

## Requirements
- R1: After reset the port enable (active low) is high, the read/not-write select is high, out_valid, out_last, busy, done and err are all low.
- R2: An accepted start causes exactly 18 port writes on consecutive cycles, in this order: 0xFFFFFFFF, 0xAA995566, 0x20000000, 0x20000000, 0x30008001, 0x00000007, 0x20000000, 0x20000000, 0x30008001, 0x00000004, 0x20000000 three times, 0x30002001, the frame address, the read header, then 0x20000000 twice.
- R3: The frame-address word is the far_in value captured at start, even if far_in changes later. The read header is 0x28006000 OR'd with 81*(nframes+1): type 1 in bits 31:29, opcode 1 (read) in bits 28:27, register 3 in bits 17:13, and the count in bits 10:0.
- R4: Writes drive enable low and select low. Between the last write and the first read there is exactly one cycle with enable high. Reads drive enable low and select high.
- R5: The port is strobed for a read exactly 81*(nframes+1) times. The first 81 words are dropped. The output then carries the remaining words in order, with no loss or repeat.
- R6: After the dummy frame, no read strobe occurs while out_valid is high and out_ready is low. out_data holds steady until the word is accepted.
- R7: out_last is high only on the final output word, word 81*nframes.
- R8: done pulses for exactly one cycle, in the cycle after the final word is accepted. busy is low from that cycle on.
- R9: A start with nframes of 0, or with 81*(nframes+1) above 2047, gives a one-cycle err pulse in the next cycle. It causes no port activity and leaves busy low.
- R10: A start during a job is ignored. The running job's words are unchanged, only one done pulse appears, and the port stays quiet afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request pulse |
| far_in | input | 32 | Starting frame address |
| nframes | input | 8 | Number of real frames to return |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse after the final word is accepted |
| err | output | 1 | One-cycle pulse for a refused request |
| port_en_n | output | 1 | Configuration port enable, active low |
| port_rdwr | output | 1 | Port direction, 1 = read, 0 = write |
| port_wdata | output | 32 | Word written to the port |
| port_rdata | input | 32 | Word read from the port |
| out_data | output | 32 | Readback data word |
| out_valid | output | 1 | out_data holds a word |
| out_ready | input | 1 | Consumer accepts the word |
| out_last | output | 1 | Marks the final word |

## Verification
The hardest case is the boundary between the dropped dummy frame and the first real word when the consumer is stalling. In that stretch the port must keep streaming while words are dropped, then stop at once while a word waits, and resume without losing or repeating a word. The stimulus uses irregular out_ready patterns, including one that is low two cycles in three, on jobs of one and two frames. The largest legal request (24 frames) and the first illegal one (25 frames) exercise the count-field limit. A second start pulse during the command phase, with a different address, checks that the captured address and the single done pulse survive it.

// File: rtl/rb_pkg.sv
package rb_pkg;
    typedef enum logic [2:0] {ST_IDLE, ST_SEND, ST_GAP, ST_READ, ST_FLUSH} rb_state_e;

    localparam int CNT_W   = 11;
    localparam int SEQ_LEN = 18;

    localparam logic [31:0] W_PAD  = 32'hFFFF_FFFF;
    localparam logic [31:0] W_SYNC = 32'hAA99_5566;
    localparam logic [31:0] W_NOP  = 32'h2000_0000;
    localparam logic [31:0] C_RCRC = 32'd7;
    localparam logic [31:0] C_RCFG = 32'd4;

    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_WR = 2'd2;
    localparam logic [4:0] RA_FAR  = 5'd1;
    localparam logic [4:0] RA_FDRO = 5'd3;
    localparam logic [4:0] RA_CMD  = 5'd4;

    function automatic logic [31:0] hdr1(input logic [1:0] op, input logic [4:0] ra,
                                         input logic [CNT_W-1:0] wc);
        hdr1 = {3'b001, op, 9'd0, ra, 2'b00, wc};
    endfunction
endpackage

// File: rtl/rb_cmd_rom.sv
module rb_cmd_rom
    import rb_pkg::*;
(
    input  logic [4:0]       idx,
    input  logic [31:0]      far,
    input  logic [CNT_W-1:0] rcnt,
    output logic [31:0]      word
);
    always_comb begin
        unique case (idx)
            5'd0:  word = W_PAD;
            5'd1:  word = W_SYNC;
            5'd4:  word = hdr1(OP_WR, RA_CMD, 11'd1);
            5'd5:  word = C_RCRC;
            5'd8:  word = hdr1(OP_WR, RA_CMD, 11'd1);
            5'd9:  word = C_RCFG;
            5'd13: word = hdr1(OP_WR, RA_FAR, 11'd1);
            5'd14: word = far;
            5'd15: word = hdr1(OP_RD, RA_FDRO, rcnt);
            default: word = W_NOP;
        endcase
    end
endmodule

// File: rtl/rb_capture.sv
module rb_capture #(
    parameter int FRAME_WORDS = 81,
    parameter int TOT_W       = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             active,
    input  logic [TOT_W-1:0] total,
    input  logic [31:0]      rdata,
    input  logic             out_ready,
    output logic             strobe,
    output logic             final_rd,
    output logic             out_valid,
    output logic [31:0]      out_data,
    output logic             out_last
);
    localparam logic [TOT_W-1:0] FW  = TOT_W'(FRAME_WORDS);
    localparam logic [TOT_W-1:0] ONE = TOT_W'(1);

    logic [TOT_W-1:0] rcnt;
    logic             in_dummy;

    assign in_dummy = rcnt < FW;
    assign strobe   = active && (in_dummy || !out_valid || out_ready);
    assign final_rd = strobe && (rcnt == total - ONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcnt      <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else begin
            if (clear) rcnt <= '0;
            else if (strobe) rcnt <= rcnt + ONE;
            if (strobe && !in_dummy) begin
                out_valid <= 1'b1;
                out_data  <= rdata;
                out_last  <= final_rd;
            end else if (out_valid && out_ready) begin
                out_valid <= 1'b0;
                out_last  <= 1'b0;
            end
        end
    end

    // R6: a waiting word is held unchanged
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R7: the last flag only rides on a valid word
    a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

// File: rtl/rb_readback_seq.sv
module rb_readback_seq
    import rb_pkg::*;
#(
    parameter int NFR_W       = 8,
    parameter int FRAME_WORDS = 81
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      far_in,
    input  logic [NFR_W-1:0] nframes,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             port_en_n,
    output logic             port_rdwr,
    output logic [31:0]      port_wdata,
    input  logic [31:0]      port_rdata,
    output logic [31:0]      out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_last
);
    localparam int TOTW = NFR_W + $clog2(FRAME_WORDS + 1);
    localparam logic [TOTW-1:0] CNT_MAX  = TOTW'((1 << CNT_W) - 1);
    localparam logic [4:0]      LAST_IDX = 5'(SEQ_LEN - 1);

    rb_state_e        state, state_nx;
    logic [4:0]       idx;
    logic [31:0]      far_q;
    logic [CNT_W-1:0] total_q;
    logic [TOTW-1:0]  req_total;
    logic             req_ok, accept;
    logic [31:0]      rom_word;
    logic             strobe, final_rd;

    assign req_total = (TOTW'(nframes) + TOTW'(1)) * TOTW'(FRAME_WORDS);
    assign req_ok    = (nframes != '0) && (req_total <= CNT_MAX);
    assign accept    = (state == ST_IDLE) && start && req_ok;
    assign busy      = (state != ST_IDLE);

    rb_cmd_rom u_rom (.idx(idx), .far(far_q), .rcnt(total_q), .word(rom_word));

    rb_capture #(.FRAME_WORDS(FRAME_WORDS), .TOT_W(CNT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .clear(accept), .active(state == ST_READ),
        .total(total_q), .rdata(port_rdata), .out_ready(out_ready),
        .strobe(strobe), .final_rd(final_rd), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_SEND;
            ST_SEND:  if (idx == LAST_IDX) state_nx = ST_GAP;
            ST_GAP:   state_nx = ST_READ;
            ST_READ:  if (final_rd) state_nx = ST_FLUSH;
            ST_FLUSH: if (out_valid && out_ready) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            far_q   <= '0;
            total_q <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= (state == ST_FLUSH) && out_valid && out_ready;
            err   <= (state == ST_IDLE) && start && !req_ok;
            if (accept) begin
                idx     <= '0;
                far_q   <= far_in;
                total_q <= req_total[CNT_W-1:0];
            end else if (state == ST_SEND) begin
                idx <= idx + 5'd1;
            end
        end
    end

    always_comb begin
        port_en_n  = 1'b1;
        port_rdwr  = 1'b1;
        port_wdata = '0;
        unique case (state)
            ST_SEND: begin
                port_en_n  = 1'b0;
                port_rdwr  = 1'b0;
                port_wdata = rom_word;
            end
            ST_READ: port_en_n = !strobe;
            default: ;
        endcase
    end

    // R4: a write is never followed directly by a read
    a_r4_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en_n && !port_rdwr) |=> !(!port_en_n && port_rdwr));
    // R5: the port is quiet while no job runs
    a_r5_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> port_en_n);
    // R8: done lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: a refusal touches nothing
    a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (port_en_n && !busy));
endmodule

// File: tb/rb_readback_seq_test.sv
module rb_readback_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] far_in = '0;
    logic [7:0]  nframes = '0;
    logic        busy, done, err, port_en_n, port_rdwr, out_valid, out_last;
    logic [31:0] port_wdata, out_data;
    logic [31:0] port_rdata = '0;
    logic        out_ready = 1'b1;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rb_readback_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .far_in(far_in), .nframes(nframes),
        .busy(busy), .done(done), .err(err), .port_en_n(port_en_n), .port_rdwr(port_rdwr),
        .port_wdata(port_wdata), .port_rdata(port_rdata), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last));

    function automatic logic [31:0] pat(input int k);
        pat = 32'hC0DE_0000 ^ (32'(k) * 32'h0000_9E37);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit ready_of(input int mode, input int c);
        case (mode)
            0: ready_of = 1'b1;
            1: ready_of = !((c % 4) == 1 || (c % 7) == 3);
            default: ready_of = ((c % 3) == 0);
        endcase
    endfunction

    task automatic run_job(input logic [31:0] far, input int n, input int mode, input bit inject);
        logic [31:0] exp [18];
        int total, widx, rk, acc, gaps, dones, cyc;
        bit rd_now, fin;
        total = 81 * (n + 1);
        foreach (exp[i]) exp[i] = 32'h2000_0000;
        exp[0] = 32'hFFFF_FFFF; exp[1] = 32'hAA99_5566;
        exp[4] = 32'h3000_8001; exp[5] = 32'h0000_0007;
        exp[8] = 32'h3000_8001; exp[9] = 32'h0000_0004;
        exp[13] = 32'h3000_2001; exp[14] = far;
        exp[15] = 32'h2800_6000 | 32'(total);
        @(negedge clk);
        start = 1'b1; far_in = far; nframes = 8'(n);
        @(negedge clk);
        start = 1'b0; far_in = ~far;
        widx = 0; rk = 0; acc = 0; gaps = 0; dones = 0; fin = 0;
        for (cyc = 0; cyc < 20000 && !fin; cyc++) begin
            port_rdata = pat(rk);
            out_ready  = ready_of(mode, cyc);
            if (inject && cyc == 5) begin start = 1'b1; far_in = 32'h1234_5678; nframes = 8'd3; end
            else start = 1'b0;
            #1;
            rd_now = 1'b0;
            if (!port_en_n && !port_rdwr) begin
                chk(widx < 18, "R2 write count", 32'(widx), 32'd17);
                if (widx < 18) chk(port_wdata == exp[widx], (widx == 14 || widx == 15) ? "R3 word" : "R2 word", port_wdata, exp[widx]);
                widx++;
            end else if (!port_en_n && port_rdwr) begin
                if (rk == 0) chk(widx == 18 && gaps == 1, "R4 turnaround", 32'(gaps), 32'd1);
                if (rk >= 81) chk(!(out_valid && !out_ready), "R6 stall", 32'(rk), 32'd0);
                chk(rk < total, "R5 excess read", 32'(rk), 32'(total));
                rd_now = 1'b1;
            end else if (widx == 18 && rk == 0) begin
                gaps++;
            end
            if (out_valid && out_ready) begin
                chk(out_data == pat(81 + acc), "R5 data", out_data, pat(81 + acc));
                chk(out_last == (acc == 81 * n - 1), "R7 last", 32'(out_last), 32'(acc == 81 * n - 1));
                acc++;
            end
            if (done) begin
                dones++;
                chk(acc == 81 * n && rk == total, "R5 totals", 32'(acc), 32'(81 * n));
                chk(!busy, "R8 busy at done", 32'(busy), 32'd0);
                fin = 1'b1;
            end
            @(negedge clk);
            if (rd_now) rk++;
        end
        chk(fin, "R8 done seen", 32'(fin), 32'd1);
        #1;
        chk(!done, "R8 done width", 32'(done), 32'd0);
        for (int q = 0; q < 6; q++) begin
            chk(port_en_n && !busy, inject ? "R10 quiet after" : "R8 idle after", 32'(port_en_n), 32'd1);
            @(negedge clk); #1;
        end
        out_ready = 1'b1;
    endtask

    task automatic reject(input int n);
        @(negedge clk);
        start = 1'b1; nframes = 8'(n); far_in = 32'hDEAD_0000;
        @(negedge clk);
        start = 1'b0; #1;
        chk(err == 1'b1, "R9 err pulse", 32'(err), 32'd1);
        chk(port_en_n && !busy, "R9 no activity", 32'(busy), 32'd0);
        for (int q = 0; q < 8; q++) begin
            @(negedge clk); #1;
            chk(port_en_n && !busy && !err, "R9 quiet", 32'(port_en_n), 32'd1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(port_en_n && port_rdwr, "R1 port idle", {port_en_n, port_rdwr}, 32'd3);
        chk(!out_valid && !out_last && !busy && !done && !err, "R1 flags", 32'(busy), 32'd0);
        rst_n = 1'b1;
        run_job(32'h0000_0000, 1, 0, 1'b0);
        run_job(32'h0030_8000, 2, 1, 1'b0);
        run_job(32'h0010_0102, 1, 2, 1'b0);
        run_job(32'h00A5_5A01, 3, 0, 1'b1);
        run_job(32'h0000_0080, 24, 1, 1'b0);
        reject(25);
        reject(0);
        run_job(32'h0020_0005, 2, 2, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule